// File: doc/BRIEF.md
# SPI Device Identification Responder

This block is the part of a serial memory's slave interface that answers the standard identification query. A host pulls chip select low and shifts in one 8-bit command, most significant bit first, on the rising edges of the serial clock. If that command is 9Fh, the block answers on the falling edges that follow. It sends four bytes in this order: the manufacturer code, the upper device-code byte, the lower device-code byte, and a length byte of 00h, which tells the host that no extended data follows. After those bytes the block stops driving the output for as long as chip select stays low. Any other command gets no output for the whole transaction.

The block runs on a fast system clock and samples the serial pins through synchronizer stages. This keeps every flop in one clock domain. The cost is that the serial clock must run well below the system clock. The output pin is given as a data bit and a drive enable, and the pad drives high impedance whenever the enable is low. The manufacturer code and the 16-bit device code are parameters.

Top module: `id_responder`

## Requirements
- R1: After synchronous active-low reset, `so_oe` and `so_data` are both 0.
- R2: While `cs_n` is low, the command is taken from `si` on eight rising `sck` edges, most significant bit first. During those eight bits `so_oe` stays 0.
- R3: If the command equals 9Fh, the falling `sck` edge right after the eighth command bit raises `so_oe` and puts the most significant bit of the manufacturer code on `so_data`.
- R4: Each later falling `sck` edge moves the output to the next bit, most significant bit first. The 32 bits go out as `{MFR_ID, DEV_ID[15:8], DEV_ID[7:0], 8'h00}`, and `so_data` changes only after a falling edge.
- R5: On the falling edge after the 32nd output bit, `so_oe` drops to 0 and stays 0 for any further clocks until `cs_n` rises.
- R6: A command other than 9Fh keeps `so_oe` at 0 for the rest of the transaction, whatever follows on `si`.
- R7: When `cs_n` is high for 4 system clocks, `so_oe` is 0 and all command and output progress is cleared. The next transaction then starts from the first command bit. This holds both in the middle of a command and in the middle of the reply.
- R8: Every response to a serial pin change appears on the ports at the third rising system-clock edge after the change. For this to hold, each `sck` phase must last at least 4 system clocks.
- R9: `MFR_ID` and `DEV_ID` are parameters. Two instances with different values each send their own codes.
- R10: Whenever `so_oe` is 0, `so_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Chip select from the host, active low |
| si | input | 1 | Serial data from the host |
| so_data | output | 1 | Serial data to the host, meaningful while `so_oe` is 1 |
| so_oe | output | 1 | Drive enable for the output pad; the pad floats when this is 0 |

## Verification
Each result is due three system clocks after the serial edge that causes it: two synchronizer stages, then the register that acts on the detected edge. The bench therefore waits a fixed six system clocks after each falling `sck` edge and samples on the falling system-clock edge, before the next rising `sck` edge. That sample sees the bit from the finished falling edge and nothing from the next rising edge. After `cs_n` rises, the bench waits four system clocks before it checks that the output is released. The expected reply bits come from the parameter values that the bench itself concatenates.

// File: rtl/id_resp_pkg.sv
// Package: shared definitions for the identification responder.
// Assumes: included first in compile order.
package id_resp_pkg;

    // Command code that selects the identification reply
    localparam logic [7:0] ID_READ_CMD = 8'h9F;

    // Length byte that ends the reply (no extended data)
    localparam logic [7:0] EXT_LEN_NONE = 8'h00;

    // Reply sequencer states
    typedef enum logic [1:0] {
        TX_WAIT = 2'd0,   // command not complete yet
        TX_SEND = 2'd1,   // reply bits being shifted out
        TX_HOLD = 2'd2    // reply finished or command rejected
    } tx_state_t;

endpackage

// File: rtl/id_resp_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent; STAGES >= 2; RST_VAL is the idle level.
module id_resp_sync #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pins into the first stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                // Pass the value down the synchronizer chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/id_resp_edge.sv
// Module: edge detector for the synchronized serial clock.
// Assumes: lvl is already synchronized to clk; reset level is low (idle sck).
module id_resp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/id_resp_cmd_rx.sv
// Module: command receiver; shifts CMD_W bits MSB first on sck rising edges
//         and flags a hit or miss against CMD_CODE on the last bit.
// Assumes: cs_act and rise are synchronized; inactive select clears progress.
module id_resp_cmd_rx #(
    parameter int unsigned CMD_W = 8,
    parameter logic [CMD_W-1:0] CMD_CODE = 8'h9F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic rise,
    input  logic si,
    output logic cmd_hit,
    output logic cmd_miss
);

    localparam int unsigned CNT_W = $clog2(CMD_W + 1);

    logic [CMD_W-1:0] shift_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] next_word;
    logic             last_bit;

    assign next_word = {shift_q[CMD_W-2:0], si};
    assign last_bit  = rise && (cnt_q == CNT_W'(CMD_W - 1));
    assign cmd_hit   = last_bit && (next_word == CMD_CODE);
    assign cmd_miss  = last_bit && (next_word != CMD_CODE);

    // Shift command bits in and count them; stop after CMD_W bits
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (rise && (cnt_q < CNT_W'(CMD_W))) begin
            shift_q <= next_word;
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/id_resp_tx.sv
// Module: reply sequencer; after a command hit, shifts FRAME out MSB first
//         on sck falling edges, then releases the output.
// Assumes: cmd_hit / cmd_miss are single-cycle pulses on an sck rising edge.
module id_resp_tx
    import id_resp_pkg::*;
#(
    parameter int unsigned FRAME_W = 32,
    parameter logic [FRAME_W-1:0] FRAME = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic fall,
    input  logic cmd_hit,
    input  logic cmd_miss,
    output logic so_data,
    output logic so_oe
);

    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

    tx_state_t        state_q;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0] cnt_q;
    logic             oe_q;
    logic             bit_q;

    // Sequence the reply: wait for command, send FRAME_W bits, then hold
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            state_q <= TX_WAIT;
            shift_q <= '0;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            case (state_q)
                TX_WAIT: begin
                    if (cmd_hit) begin
                        state_q <= TX_SEND;
                        shift_q <= FRAME;
                    end else if (cmd_miss) begin
                        state_q <= TX_HOLD;
                    end
                end
                TX_SEND: begin
                    if (fall) begin
                        if (cnt_q == CNT_W'(FRAME_W)) begin
                            state_q <= TX_HOLD;
                            oe_q    <= 1'b0;
                            bit_q   <= 1'b0;
                        end else begin
                            oe_q    <= 1'b1;
                            bit_q   <= shift_q[FRAME_W-1];
                            shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign so_data = bit_q;
    assign so_oe   = oe_q;

endmodule

// File: rtl/id_responder.sv
// Module: top of the identification responder. Synchronizes the serial
//         pins, detects sck edges, receives the command and sends the
//         identification frame {MFR_ID, DEV_ID, 00h}.
// Assumes: SPI mode 0 (sck idle low); each sck phase >= 4 clk cycles.
module id_responder
    import id_resp_pkg::*;
#(
    parameter logic [7:0]  MFR_ID = 8'h1F,
    parameter logic [15:0] DEV_ID = 16'h4701,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so_data,
    output logic so_oe
);

    localparam int unsigned PIN_W   = 3;
    localparam int unsigned FRAME_W = 8 + 16 + 8;
    localparam logic [FRAME_W-1:0] ID_FRAME = {MFR_ID, DEV_ID, EXT_LEN_NONE};

    logic [PIN_W-1:0] pins_s;
    logic             cs_act;
    logic             sck_rise;
    logic             sck_fall;
    logic             cmd_hit;
    logic             cmd_miss;

    id_resp_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, si}),
        .dout  (pins_s)
    );

    assign cs_act = ~pins_s[2];

    id_resp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pins_s[1]),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    id_resp_cmd_rx #(
        .CMD_W    (8),
        .CMD_CODE (ID_READ_CMD)
    ) u_cmd_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .rise     (sck_rise),
        .si       (pins_s[0]),
        .cmd_hit  (cmd_hit),
        .cmd_miss (cmd_miss)
    );

    id_resp_tx #(
        .FRAME_W (FRAME_W),
        .FRAME   (ID_FRAME)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .fall     (sck_fall),
        .cmd_hit  (cmd_hit),
        .cmd_miss (cmd_miss),
        .so_data  (so_data),
        .so_oe    (so_oe)
    );

endmodule

// File: rtl/id_responder_chk.sv
// Module: property checker for id_responder, attached by bind.
// Assumes: observes ports plus the sck edge pulses of the top.
module id_responder_chk #(
    parameter logic [7:0] MFR_ID = 8'h1F
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so_data,
    input logic so_oe,
    input logic sck_fall
);

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    // R3
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> (so_data == MFR_ID[7]));

    // R3
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_fall));

    // R4
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$stable(so_data)) |-> $past(sck_fall));

    // R10
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> !so_data);

endmodule

bind id_responder id_responder_chk #(.MFR_ID(MFR_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .so_data  (so_data),
    .so_oe    (so_oe),
    .sck_fall (sck_fall)
);

// File: tb/test_id_responder.sv
`timescale 1ns/1ps
// Bench: drives two responders with different ID parameters through the
// same serial traffic and checks every sampled output bit.
module test_id_responder;

    localparam int HALF = 6;
    localparam logic [7:0]  MFR_A = 8'h1F;
    localparam logic [15:0] DEV_A = 16'h4701;
    localparam logic [7:0]  MFR_B = 8'hC2;
    localparam logic [15:0] DEV_B = 16'h2016;
    localparam logic [31:0] FRM_A = {MFR_A, DEV_A, 8'h00};
    localparam logic [31:0] FRM_B = {MFR_B, DEV_B, 8'h00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so_a, oe_a, so_b, oe_b;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    id_responder #(.MFR_ID(MFR_A), .DEV_ID(DEV_A)) i_id_responder (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_data(so_a), .so_oe(oe_a)
    );

    id_responder #(.MFR_ID(MFR_B), .DEV_ID(DEV_B)) i_id_responder_alt (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_data(so_b), .so_oe(oe_b)
    );

    task automatic check_out(input string req, input logic eoa, input logic esa,
                             input logic eob, input logic esb);
        total += 1;
        if (oe_a !== eoa || so_a !== esa) begin
            bad += 1;
            $display("FAIL %s inst A: oe/so=%b%b expected %b%b", req, oe_a, so_a, eoa, esa);
        end
        total += 1;
        if (oe_b !== eob || so_b !== esb) begin
            bad += 1;
            $display("FAIL %s inst B: oe/so=%b%b expected %b%b", req, oe_b, so_b, eob, esb);
        end
    endtask

    // One sck period; returns HALF clocks after the falling edge
    task automatic tick(input logic b);
        si = b;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_up();
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check_out("R7 release", 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (2 * HALF) @(negedge clk);
    endtask

    // Identification read of n data ticks, then deselect
    task automatic read_id(input int n);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            tick(id_resp_pkg::ID_READ_CMD[7-i]);
            check_out("R2 command phase", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        tick(id_resp_pkg::ID_READ_CMD[0]);
        check_out("R3 first bit", 1'b1, FRM_A[31], 1'b1, FRM_B[31]);
        for (int k = 1; k < n; k++) begin
            tick(1'b1);
            if (k < 32)
                check_out("R4 R9 frame bit", 1'b1, FRM_A[31-k], 1'b1, FRM_B[31-k]);
            else
                check_out("R5 released after frame", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        cs_up();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);

        // Full reply and trailing clocks
        read_id(40);

        // R7: abort in the middle of the command
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 4; i++) tick(id_resp_pkg::ID_READ_CMD[7-i]);
        cs_up();
        read_id(34);

        // R7: host stops early in the reply, next read starts fresh
        read_id(12);
        read_id(33);

        // R6: every other command yields no output
        for (int op = 0; op < 256; op++) begin
            if (op != 8'h9F) begin
                cs_n = 1'b0;
                repeat (HALF) @(negedge clk);
                for (int i = 0; i < 16; i++) begin
                    tick((i < 8) ? op[7-i] : ((i % 2) == 1));
                    check_out("R6 other command", 1'b0, 1'b0, 1'b0, 1'b0);
                end
                cs_up();
            end
        end

        // R7 and R8: reply still correct after the sweep
        read_id(36);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad += 1;
        total += 1;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule